// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is a single compare channel that watches a free-running time counter and acts when the counter reaches a programmed target. It is mainly used to produce a once-per-second marker on an output pin. On each match the channel sets an event flag. It can raise an interrupt, and it drives its pin according to a four-bit mode: the pin either flips state or emits a short high pulse.

The target register is double-buffered. While the channel runs, software writes the target after next, so the next event is never disturbed by a late write. The first target written after the channel is switched off is loaded directly, which lets software seed the first event before enabling. A separate enable input decides whether a match that falls on the counter's wrap cycle counts.

Top module: `cmp_pulse_channel`

## Requirements
- R1: After reset the control word and the target both read as zero, the pin is low and the interrupt is low.
- R2: The control word (address 0) holds the request-enable bit at bit 0, the mode at bits 5:2 and the interrupt-enable bit at bit 6, and all of them read back as written. The event flag at bit 7 is cleared by writing 1 to bit 7. Writing 0 there leaves it unchanged.
- R3: With a nonzero mode and a loaded target, the counter equal to the target sets the event flag on the next clock edge. With mode 0 a match has no effect.
- R4: A write to the target (address 1) while the mode is 0 replaces the active target at once, and a read of address 1 returns the active target.
- R5: While the channel runs with a loaded target, a target write is queued. The queued value becomes the active target on the next match, and a later write before that match replaces the queued value.
- R6: If nothing is queued at a match, the target is kept and the next event occurs only when the counter comes back to it.
- R7: Mode 0x5 inverts the pin on every match.
- R8: Mode 0xF drives the pin high on a match for PULSE_LEN clock cycles, after which it returns low.
- R9: The interrupt output is high exactly when the event flag and the interrupt-enable bit are both set.
- R10: A match in a cycle where the wrap indication is high counts only while the wrap-event enable input is high.
- R11: A counter that stays at the target for several cycles produces one event.
- R12: Setting the mode to 0 drives the pin low and discards the loaded target state, so the first target write after that loads directly even if the channel has already been re-enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Current time counter value |
| cnt_wrap_i | input | 1 | High in the cycle the counter has just wrapped to zero |
| wrap_evt_en_i | input | 1 | Allows matches in the wrap cycle |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | 0 selects the control word, 1 the target |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected register |
| pin_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the channel with an 8-bit counter and a 3-cycle pulse. With these values the bench can walk the counter through a full wrap in a few steps, so both the wrap-cycle masking and the "match again only after wraparound" rule are reached quickly. A pulse of three cycles shows every cycle of the high phase and the cycle it ends. Target values are chosen so that the queued, overwritten and directly loaded targets can each be told apart by a read of the target address.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;
    localparam int REG_W    = 32;
    localparam int DRE_BIT  = 0;
    localparam int MODE_LSB = 2;
    localparam int MODE_MSB = 5;
    localparam int IE_BIT   = 6;
    localparam int FLAG_BIT = 7;

    typedef logic [3:0] mode_t;

    localparam mode_t MODE_OFF    = 4'h0;
    localparam mode_t MODE_TOGGLE = 4'h5;
    localparam mode_t MODE_PULSE  = 4'hF;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_TGT  = 1'b1
    } sel_t;
endpackage

// File: rtl/cmp_chan_target.sv
module cmp_chan_target #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_on,
    input  logic             wr_tgt,
    input  logic [CNT_W-1:0] wdata,
    input  logic             hit,
    output logic [CNT_W-1:0] target,
    output logic             armed
);
    typedef struct packed {
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] queued;
        logic             q_valid;
        logic             armed;
        logic             was_on;
    } tgt_st_t;

    tgt_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.was_on = chan_on;
        // switching off drops any loaded or queued target
        if (st_q.was_on && !chan_on) begin
            st_d.armed   = 1'b0;
            st_d.q_valid = 1'b0;
        end
        // a match promotes the queued target
        if (hit && st_q.q_valid) begin
            st_d.active  = st_q.queued;
            st_d.q_valid = 1'b0;
        end
        if (wr_tgt) begin
            if (!chan_on || !st_d.armed) begin
                st_d.active  = wdata;
                st_d.armed   = 1'b1;
                st_d.q_valid = 1'b0;
            end else begin
                st_d.queued  = wdata;
                st_d.q_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign target = st_q.active;
    assign armed  = st_q.armed;

    assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tgt && !chan_on) |=> (target == $past(wdata)));

    assert_queue_promote_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.q_valid) |=> (target == $past(st_q.queued)));

    assert_keep_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !st_q.q_valid) |=> (target == $past(target)));
endmodule

// File: rtl/cmp_chan_detect.sv
module cmp_chan_detect #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] target,
    input  logic             armed,
    input  logic             chan_on,
    input  logic             at_wrap,
    input  logic             wrap_en,
    output logic             hit
);
    typedef struct packed {
        logic eq_prev;
    } det_st_t;

    det_st_t st_d, st_q;
    logic    eq;

    always_comb begin
        eq         = armed && chan_on && (cnt == target) && (!at_wrap || wrap_en);
        hit        = eq && !st_q.eq_prev;
        st_d       = st_q;
        st_d.eq_prev = eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_hit_needs_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (chan_on && armed));

    assert_single_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $stable(cnt)) |=> !hit);

    assert_wrap_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (at_wrap && !wrap_en) |-> !hit);
endmodule

// File: rtl/cmp_chan_drive.sv
module cmp_chan_drive
    import cmp_chan_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  hit,
    output logic  pin
);
    localparam int LW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic          pin;
        logic [LW-1:0] left;
    } drv_st_t;

    drv_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode == MODE_OFF) begin
            st_d.pin  = 1'b0;
            st_d.left = '0;
        end else if (hit && mode == MODE_TOGGLE) begin
            st_d.pin  = !st_q.pin;
            st_d.left = '0;
        end else if (hit && mode == MODE_PULSE) begin
            st_d.pin  = 1'b1;
            st_d.left = LW'(PULSE_LEN - 1);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end else if (mode == MODE_PULSE && st_q.pin) begin
            st_d.pin = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;

    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == MODE_TOGGLE) |=> (pin != $past(pin)));

    assert_pulse_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && mode == MODE_PULSE) |=> pin);

    assert_off_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> !pin);
endmodule

// File: rtl/cmp_pulse_channel.sv
module cmp_pulse_channel
    import cmp_chan_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             cnt_wrap_i,
    input  logic             wrap_evt_en_i,
    input  logic             bus_we_i,
    input  logic             bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    output logic             pin_o,
    output logic             irq_o
);
    typedef struct packed {
        logic  dre;
        mode_t mode;
        logic  ie;
        logic  flag;
    } ctrl_st_t;

    ctrl_st_t         st_d, st_q;
    logic             wr_ctrl;
    logic             wr_tgt;
    logic             chan_on;
    logic             hit;
    logic             armed;
    logic [CNT_W-1:0] target;

    assign wr_ctrl = bus_we_i && (sel_t'(bus_addr_i) == SEL_CTRL);
    assign wr_tgt  = bus_we_i && (sel_t'(bus_addr_i) == SEL_TGT);
    assign chan_on = (st_q.mode != MODE_OFF);

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.dre  = bus_wdata_i[DRE_BIT];
            st_d.mode = bus_wdata_i[MODE_MSB:MODE_LSB];
            st_d.ie   = bus_wdata_i[IE_BIT];
            if (bus_wdata_i[FLAG_BIT]) st_d.flag = 1'b0;
        end
        // a new event wins over a clear in the same cycle
        if (hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (sel_t'(bus_addr_i) == SEL_TGT) begin
            bus_rdata_o = REG_W'(target);
        end else begin
            bus_rdata_o[DRE_BIT]           = st_q.dre;
            bus_rdata_o[MODE_MSB:MODE_LSB] = st_q.mode;
            bus_rdata_o[IE_BIT]            = st_q.ie;
            bus_rdata_o[FLAG_BIT]          = st_q.flag;
        end
    end

    assign irq_o = st_q.flag && st_q.ie;

    cmp_chan_target #(.CNT_W(CNT_W)) u_target (
        .clk     (clk),
        .rst_n   (rst_n),
        .chan_on (chan_on),
        .wr_tgt  (wr_tgt),
        .wdata   (bus_wdata_i[CNT_W-1:0]),
        .hit     (hit),
        .target  (target),
        .armed   (armed)
    );

    cmp_chan_detect #(.CNT_W(CNT_W)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt_i),
        .target  (target),
        .armed   (armed),
        .chan_on (chan_on),
        .at_wrap (cnt_wrap_i),
        .wrap_en (wrap_evt_en_i),
        .hit     (hit)
    );

    cmp_chan_drive #(.PULSE_LEN(PULSE_LEN)) u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (st_q.mode),
        .hit   (hit),
        .pin   (pin_o)
    );

    assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(hit));

    assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata_i[FLAG_BIT] && !hit) |=> !st_q.flag);

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata_i[IE_BIT]) |=> !irq_o);
endmodule

// File: tb/cmp_pulse_channel_test.sv
module cmp_pulse_channel_test;
    localparam int CW = 8;
    localparam int PL = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt = 8'h10;
    logic          wrap = 1'b0;
    logic          wrap_en = 1'b0;
    logic          we = 1'b0;
    logic          addr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          pin;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = !clk;

    cmp_pulse_channel #(.CNT_W(CW), .PULSE_LEN(PL)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_i         (cnt),
        .cnt_wrap_i    (wrap),
        .wrap_evt_en_i (wrap_en),
        .bus_we_i      (we),
        .bus_addr_i    (addr),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .pin_o         (pin),
        .irq_o         (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic step(input logic [CW-1:0] v, input logic w);
        @(negedge clk);
        cnt = v; wrap = w;
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(1'b0, v); chk("R1 ctrl", v, 32'h0);
        rd(1'b1, v); chk("R1 target", v, 32'h0);
        chk("R1 pin", 32'(pin), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] v;
        wr(1'b0, 32'h4D);
        rd(1'b0, v); chk("R2 fields", v, 32'h4D);
        wr(1'b0, 32'h0);
        rd(1'b0, v); chk("R2 fields off", v, 32'h0);
    endtask

    task automatic t_direct;
        logic [31:0] v;
        wr(1'b1, 32'h20);
        rd(1'b1, v); chk("R4 direct", v, 32'h20);
        wr(1'b1, 32'h30);
        rd(1'b1, v); chk("R4 direct again", v, 32'h30);
        step(8'h30, 1'b0);
        rd(1'b0, v); chk("R3 off no flag", v, 32'h0);
        chk("R3 off pin", 32'(pin), 32'h0);
        step(8'h10, 1'b0);
    endtask

    task automatic t_toggle;
        logic [31:0] v;
        wr(1'b0, 32'h54);
        wr(1'b1, 32'h50);
        rd(1'b1, v); chk("R5 queued not active", v, 32'h30);
        step(8'h30, 1'b0);
        chk("R7 toggle high", 32'(pin), 32'h1);
        chk("R9 irq set", 32'(irq), 32'h1);
        rd(1'b0, v); chk("R3 flag set", v, 32'hD4);
        rd(1'b1, v); chk("R5 promoted", v, 32'h50);
        wr(1'b0, 32'hD4);
        chk("R2 w1c", 32'(irq), 32'h0);
        step(8'h31, 1'b0);
        step(8'h50, 1'b0);
        chk("R7 toggle low", 32'(pin), 32'h0);
        wr(1'b0, 32'h54);
        rd(1'b0, v); chk("R2 write 0 keeps flag", v, 32'hD4);
        wr(1'b0, 32'h14);
        chk("R9 irq masked", 32'(irq), 32'h0);
        rd(1'b0, v); chk("R9 flag still set", v, 32'h94);
        wr(1'b0, 32'hD4);
        step(8'h50, 1'b0);
        step(8'h50, 1'b0);
        chk("R11 held pin", 32'(pin), 32'h0);
        chk("R11 held irq", 32'(irq), 32'h0);
    endtask

    task automatic t_rematch;
        logic [31:0] v;
        step(8'h60, 1'b0);
        chk("R6 no event", 32'(pin), 32'h0);
        rd(1'b1, v); chk("R6 target kept", v, 32'h50);
        step(8'hFF, 1'b0);
        step(8'h00, 1'b1);
        step(8'h50, 1'b0);
        chk("R6 event after wrap", 32'(pin), 32'h1);
        chk("R6 irq", 32'(irq), 32'h1);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(1'b0, 32'h80);
        wr(1'b1, 32'h00);
        chk("R12 pin low", 32'(pin), 32'h0);
        rd(1'b1, v); chk("R4 load while off", v, 32'h00);
        wr(1'b0, 32'h54);
        wrap_en = 1'b0;
        step(8'hFF, 1'b0);
        step(8'h00, 1'b1);
        chk("R10 masked pin", 32'(pin), 32'h0);
        chk("R10 masked irq", 32'(irq), 32'h0);
        step(8'hFF, 1'b0);
        wrap_en = 1'b1;
        step(8'h00, 1'b1);
        chk("R10 allowed pin", 32'(pin), 32'h1);
        chk("R10 allowed irq", 32'(irq), 32'h1);
        wrap_en = 1'b0;
    endtask

    task automatic t_reenable;
        logic [31:0] v;
        wr(1'b0, 32'h80);
        wr(1'b0, 32'h54);
        chk("R12 pin after off", 32'(pin), 32'h0);
        wr(1'b1, 32'h70);
        rd(1'b1, v); chk("R12 first write direct", v, 32'h70);
    endtask

    task automatic t_pulse;
        logic [31:0] v;
        wr(1'b0, 32'h3C);
        wr(1'b1, 32'h90);
        wr(1'b1, 32'hA0);
        rd(1'b1, v); chk("R5 still active", v, 32'h70);
        step(8'h70, 1'b0);
        chk("R8 pulse c1", 32'(pin), 32'h1);
        step(8'h71, 1'b0);
        chk("R8 pulse c2", 32'(pin), 32'h1);
        step(8'h72, 1'b0);
        chk("R8 pulse c3", 32'(pin), 32'h1);
        step(8'h73, 1'b0);
        chk("R8 pulse end", 32'(pin), 32'h0);
        rd(1'b1, v); chk("R5 overwrite queued", v, 32'hA0);
        rd(1'b0, v); chk("R3 pulse flag", v, 32'hBC);
        chk("R9 ie off", 32'(irq), 32'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_direct();
        t_toggle();
        t_rematch();
        t_wrap();
        t_reenable();
        t_pulse();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule